// File: doc/BRIEF.md
# Scaler Window and Border Generator

This block sits in front of a display scaler. It takes the active raster size and a destination rectangle inside it, and works out the four border widths around that rectangle. The right and bottom borders are found by subtraction. Results below zero are clamped and reported on a sticky error flag. A debug input widens the right and bottom borders by two pixels so that the scaled picture stands out visibly.

It also rounds a source viewport to even coordinates for luma, and derives a chroma viewport from it. For 4:2:0 content the chroma viewport is halved; for other formats it is a plain copy. For each active-area pixel coordinate it reports, one cycle later, whether the pixel lies inside the rectangle. It also reports which source coordinate the pixel should take. A border pixel either takes a constant fill colour, or repeats the nearest edge pixel of the rectangle. All configuration is sampled on a frame-start strobe, so changes made in the middle of a frame take effect only at the next frame.

Top module: `scl_window_gen`

## Requirements
- R1: On a cycle with `frame_start` high, the left border is loaded with `rect_x` and the top border with `rect_y`. The new values are visible after that clock edge.
- R2: On the same edge, the right border is loaded with `h_active - rect_x - rect_w` and the bottom border with `v_active - rect_y - rect_h`.
- R3: When `dbg_widen` is high at frame start, the right and bottom borders are each two larger than in R2.
- R4: A right or bottom result below zero, after any widening, is loaded as 0.
- R5: `brd_err` goes high after any frame start whose right or bottom result is below zero. It stays high until a cycle with `err_clear` high and no new error. If both happen in the same cycle, the new error wins.
- R6: The luma viewport is the source viewport with the lowest bit of x, y, width and height forced to 0.
- R7: When `fmt_420` is 1, each chroma viewport field is the matching luma field shifted right by one. When `fmt_420` is 0, the chroma viewport equals the luma viewport.
- R8: At frame start, the luma viewport is updated only when its rounded width and height are both nonzero. The chroma viewport is updated only when its own width and height are both nonzero. Otherwise each keeps its old value.
- R9: Changes to any configuration input without `frame_start` leave every border, viewport and pixel-classification output unchanged. The classification uses the rectangle latched at the last frame start.
- R10: `pix_inside` is registered. It is 1 one cycle after `pix_valid` is high with `rect_x <= pix_h < rect_x+rect_w` and `rect_y <= pix_v < rect_y+rect_h`. Otherwise it is 0.
- R11: `fetch_h`/`fetch_v` give, one cycle later, the pixel coordinate clamped into the rectangle on each axis (below it gives the first column/row, beyond it gives the last). `pix_fill` is 1 for a valid border pixel when the latched `edge_mode` is 0 (constant colour), and is 0 when `edge_mode` is 1 (repeat edge pixel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Samples all configuration |
| h_active | input | CW | Active width |
| v_active | input | CW | Active height |
| rect_x | input | CW | Destination rectangle left |
| rect_y | input | CW | Destination rectangle top |
| rect_w | input | CW | Destination rectangle width |
| rect_h | input | CW | Destination rectangle height |
| dbg_widen | input | 1 | Adds 2 to right and bottom borders |
| edge_mode | input | 1 | 0 constant fill, 1 edge repeat |
| fmt_420 | input | 1 | Source is 4:2:0 |
| src_x | input | CW | Source viewport x |
| src_y | input | CW | Source viewport y |
| src_w | input | CW | Source viewport width |
| src_h | input | CW | Source viewport height |
| err_clear | input | 1 | Clears the clamp error flag |
| pix_valid | input | 1 | Pixel coordinate valid |
| pix_h | input | CW | Pixel column in active area |
| pix_v | input | CW | Pixel row in active area |
| brd_left | output | CW | Left border |
| brd_right | output | CW | Right border |
| brd_top | output | CW | Top border |
| brd_bottom | output | CW | Bottom border |
| brd_err | output | 1 | Sticky negative-border flag |
| luma_x | output | CW | Luma viewport x |
| luma_y | output | CW | Luma viewport y |
| luma_w | output | CW | Luma viewport width |
| luma_h | output | CW | Luma viewport height |
| chroma_x | output | CW | Chroma viewport x |
| chroma_y | output | CW | Chroma viewport y |
| chroma_w | output | CW | Chroma viewport width |
| chroma_h | output | CW | Chroma viewport height |
| pix_inside | output | 1 | Pixel lies in the rectangle |
| pix_fill | output | 1 | Pixel takes the constant colour |
| fetch_h | output | CW | Source column for the pixel |
| fetch_v | output | CW | Source row for the pixel |

## Verification
The assertions assume that `frame_start` is a single-cycle strobe. They also assume that the rectangle has nonzero width and height whenever pixels are classified, so that an edge column and row exist to clamp to. The directed tasks change inputs only on falling clock edges and pulse `frame_start` for exactly one cycle. They give every pixel-scan scenario a rectangle of positive size. The stimulus also includes sizes whose rounding gives a zero width, so that the update rule for empty viewports is exercised.

// File: rtl/scl_window_pkg.sv
package scl_window_pkg;
  localparam int COORD_W = 13;

  typedef enum logic {
    FILL_CONST = 1'b0,
    FILL_EDGE  = 1'b1
  } fill_mode_e;

  localparam int VP_X = 0;
  localparam int VP_Y = 1;
  localparam int VP_W = 2;
  localparam int VP_H = 3;
  localparam int VP_FIELDS = 4;
endpackage

// File: rtl/scl_border_calc.sv
module scl_border_calc #(
  parameter int CW = scl_window_pkg::COORD_W
) (
  input  logic [CW-1:0] span,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  input  logic          widen,
  output logic [CW-1:0] near_brd,
  output logic [CW-1:0] far_brd,
  output logic          negative
);
  localparam int SW = CW + 2;

  logic [SW-1:0] raw;

  always_comb begin
    raw = {2'b00, span} - {2'b00, start} - {2'b00, len}
          + (widen ? SW'(2) : SW'(0));
    negative = raw[SW-1];
    near_brd = start;
    far_brd  = negative ? '0 : raw[CW-1:0];
  end
endmodule

// File: rtl/scl_viewport_calc.sv
module scl_viewport_calc #(
  parameter int CW = scl_window_pkg::COORD_W
) (
  input  logic [scl_window_pkg::VP_FIELDS-1:0][CW-1:0] src,
  input  logic                                         fmt420,
  output logic [scl_window_pkg::VP_FIELDS-1:0][CW-1:0] luma,
  output logic [scl_window_pkg::VP_FIELDS-1:0][CW-1:0] chroma,
  output logic                                         luma_ok,
  output logic                                         chroma_ok
);
  import scl_window_pkg::*;

  for (genvar k = 0; k < VP_FIELDS; k++) begin : g_field
    assign luma[k]   = {src[k][CW-1:1], 1'b0};
    assign chroma[k] = fmt420 ? {1'b0, luma[k][CW-1:1]} : luma[k];
  end

  assign luma_ok   = (luma[VP_W] != '0) && (luma[VP_H] != '0);
  assign chroma_ok = (chroma[VP_W] != '0) && (chroma[VP_H] != '0);
endmodule

// File: rtl/scl_pixel_scan.sv
module scl_pixel_scan #(
  parameter int CW = scl_window_pkg::COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_h,
  input  logic [CW-1:0] pix_v,
  input  logic [CW-1:0] win_x,
  input  logic [CW-1:0] win_y,
  input  logic [CW-1:0] win_w,
  input  logic [CW-1:0] win_h,
  input  scl_window_pkg::fill_mode_e mode,
  output logic          inside_q,
  output logic          fill_q,
  output logic [CW-1:0] fetch_h_q,
  output logic [CW-1:0] fetch_v_q
);
  import scl_window_pkg::*;

  localparam int AXES = 2;

  logic [AXES-1:0][CW-1:0] coord, lo, len, clamped;
  logic [AXES-1:0]         in_axis;
  logic                    inside_d, fill_d;

  assign coord = {pix_v, pix_h};
  assign lo    = {win_y, win_x};
  assign len   = {win_h, win_w};

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [CW:0]   stop;
    logic [CW-1:0] last;
    logic          below, beyond;
    always_comb begin
      stop   = {1'b0, lo[a]} + {1'b0, len[a]};
      last   = (len[a] == '0) ? lo[a] : CW'(stop - 1'b1);
      below  = coord[a] < lo[a];
      beyond = {1'b0, coord[a]} >= stop;
      in_axis[a] = !below && !beyond;
      clamped[a] = below ? lo[a] : (beyond ? last : coord[a]);
    end
  end

  always_comb begin
    inside_d = pix_valid && (&in_axis);
    fill_d   = pix_valid && !(&in_axis) && (mode == FILL_CONST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inside_q  <= 1'b0;
      fill_q    <= 1'b0;
      fetch_h_q <= '0;
      fetch_v_q <= '0;
    end else begin
      inside_q  <= inside_d;
      fill_q    <= fill_d;
      fetch_h_q <= clamped[0];
      fetch_v_q <= clamped[1];
    end
  end

  AST_INSIDE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !inside_q && !fill_q); // R10
  AST_FILL_ONLY_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> !inside_q); // R11
endmodule

// File: rtl/scl_window_gen.sv
module scl_window_gen #(
  parameter int CW = scl_window_pkg::COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [CW-1:0] h_active,
  input  logic [CW-1:0] v_active,
  input  logic [CW-1:0] rect_x,
  input  logic [CW-1:0] rect_y,
  input  logic [CW-1:0] rect_w,
  input  logic [CW-1:0] rect_h,
  input  logic          dbg_widen,
  input  logic          edge_mode,
  input  logic          fmt_420,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] src_w,
  input  logic [CW-1:0] src_h,
  input  logic          err_clear,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_h,
  input  logic [CW-1:0] pix_v,
  output logic [CW-1:0] brd_left,
  output logic [CW-1:0] brd_right,
  output logic [CW-1:0] brd_top,
  output logic [CW-1:0] brd_bottom,
  output logic          brd_err,
  output logic [CW-1:0] luma_x,
  output logic [CW-1:0] luma_y,
  output logic [CW-1:0] luma_w,
  output logic [CW-1:0] luma_h,
  output logic [CW-1:0] chroma_x,
  output logic [CW-1:0] chroma_y,
  output logic [CW-1:0] chroma_w,
  output logic [CW-1:0] chroma_h,
  output logic          pix_inside,
  output logic          pix_fill,
  output logic [CW-1:0] fetch_h,
  output logic [CW-1:0] fetch_v
);
  import scl_window_pkg::*;

  // combinational results from live inputs
  logic [CW-1:0] h_near, h_far, v_near, v_far;
  logic          h_neg, v_neg;
  logic [VP_FIELDS-1:0][CW-1:0] src_vp, luma_c, chroma_c;
  logic          luma_ok, chroma_ok;

  // latched state
  logic [CW-1:0] win_x_q, win_y_q, win_w_q, win_h_q;
  fill_mode_e    mode_q;
  logic [CW-1:0] left_q, right_q, top_q, bottom_q;
  logic [VP_FIELDS-1:0][CW-1:0] luma_q, chroma_q;
  logic          err_q, err_d;
  logic          luma_en, chroma_en;

  scl_border_calc #(.CW(CW)) u_horz (
    .span(h_active), .start(rect_x), .len(rect_w), .widen(dbg_widen),
    .near_brd(h_near), .far_brd(h_far), .negative(h_neg)
  );

  scl_border_calc #(.CW(CW)) u_vert (
    .span(v_active), .start(rect_y), .len(rect_h), .widen(dbg_widen),
    .near_brd(v_near), .far_brd(v_far), .negative(v_neg)
  );

  assign src_vp = {src_h, src_w, src_y, src_x};

  scl_viewport_calc #(.CW(CW)) u_vp (
    .src(src_vp), .fmt420(fmt_420), .luma(luma_c), .chroma(chroma_c),
    .luma_ok(luma_ok), .chroma_ok(chroma_ok)
  );

  always_comb begin
    luma_en   = frame_start && luma_ok;
    chroma_en = frame_start && chroma_ok;
    if (frame_start && (h_neg || v_neg)) err_d = 1'b1;
    else if (err_clear)                  err_d = 1'b0;
    else                                 err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_x_q  <= '0;
      win_y_q  <= '0;
      win_w_q  <= '0;
      win_h_q  <= '0;
      mode_q   <= FILL_CONST;
      left_q   <= '0;
      right_q  <= '0;
      top_q    <= '0;
      bottom_q <= '0;
    end else if (frame_start) begin
      win_x_q  <= rect_x;
      win_y_q  <= rect_y;
      win_w_q  <= rect_w;
      win_h_q  <= rect_h;
      mode_q   <= fill_mode_e'(edge_mode);
      left_q   <= h_near;
      right_q  <= h_far;
      top_q    <= v_near;
      bottom_q <= v_far;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) luma_q <= '0;
    else if (luma_en) luma_q <= luma_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chroma_q <= '0;
    else if (chroma_en) chroma_q <= chroma_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  scl_pixel_scan #(.CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_h(pix_h), .pix_v(pix_v),
    .win_x(win_x_q), .win_y(win_y_q), .win_w(win_w_q), .win_h(win_h_q),
    .mode(mode_q), .inside_q(pix_inside), .fill_q(pix_fill),
    .fetch_h_q(fetch_h), .fetch_v_q(fetch_v)
  );

  assign brd_left   = left_q;
  assign brd_right  = right_q;
  assign brd_top    = top_q;
  assign brd_bottom = bottom_q;
  assign brd_err    = err_q;
  assign luma_x     = luma_q[VP_X];
  assign luma_y     = luma_q[VP_Y];
  assign luma_w     = luma_q[VP_W];
  assign luma_h     = luma_q[VP_H];
  assign chroma_x   = chroma_q[VP_X];
  assign chroma_y   = chroma_q[VP_Y];
  assign chroma_w   = chroma_q[VP_W];
  assign chroma_h   = chroma_q[VP_H];

  AST_LEFT_FOLLOWS_X: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> brd_left == $past(rect_x) && brd_top == $past(rect_y)); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(brd_right) && $stable(brd_bottom) && $stable(luma_w)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    brd_err && !err_clear |=> brd_err); // R5
  AST_CHROMA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chroma_w <= luma_w || !$past(frame_start)); // R7
endmodule

// File: tb/scl_window_gen_test.sv
module scl_window_gen_test;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [CW-1:0] h_active = '0, v_active = '0;
  logic [CW-1:0] rect_x = '0, rect_y = '0, rect_w = '0, rect_h = '0;
  logic dbg_widen = 1'b0, edge_mode = 1'b0, fmt_420 = 1'b0;
  logic [CW-1:0] src_x = '0, src_y = '0, src_w = '0, src_h = '0;
  logic err_clear = 1'b0, pix_valid = 1'b0;
  logic [CW-1:0] pix_h = '0, pix_v = '0;
  logic [CW-1:0] brd_left, brd_right, brd_top, brd_bottom;
  logic brd_err;
  logic [CW-1:0] luma_x, luma_y, luma_w, luma_h;
  logic [CW-1:0] chroma_x, chroma_y, chroma_w, chroma_h;
  logic pix_inside, pix_fill;
  logic [CW-1:0] fetch_h, fetch_v;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_window_gen #(.CW(CW)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int ha, input int va, input int x, input int y,
                       input int w, input int h, input bit wid);
    @(negedge clk);
    h_active = CW'(ha); v_active = CW'(va);
    rect_x = CW'(x); rect_y = CW'(y); rect_w = CW'(w); rect_h = CW'(h);
    dbg_widen = wid;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pixel(input bit v, input int ph, input int pv,
                       input bit e_in, input bit e_fill, input int e_fh, input int e_fv);
    @(negedge clk);
    pix_valid = v; pix_h = CW'(ph); pix_v = CW'(pv);
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R10 inside", int'(pix_inside), int'(e_in));
    chk("R11 fill", int'(pix_fill), int'(e_fill));
    if (v) begin
      chk("R11 fetch_h", int'(fetch_h), e_fh);
      chk("R11 fetch_v", int'(fetch_v), e_fv);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset left", int'(brd_left), 0);
    chk("R2 reset right", int'(brd_right), 0);
    chk("R5 reset err", int'(brd_err), 0);
    chk("R6 reset luma_w", int'(luma_w), 0);
    chk("R10 reset inside", int'(pix_inside), 0);
  endtask

  task automatic t_borders;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    chk("R1 left", int'(brd_left), 4);
    chk("R1 top", int'(brd_top), 6);
    chk("R2 right", int'(brd_right), 64 - 4 - 40);
    chk("R2 bottom", int'(brd_bottom), 48 - 6 - 30);
    chk("R5 no err", int'(brd_err), 0);
    frame(64, 48, 4, 6, 40, 30, 1'b1);
    chk("R3 right widened", int'(brd_right), 22);
    chk("R3 bottom widened", int'(brd_bottom), 14);
  endtask

  task automatic t_clamp;
    frame(64, 48, 50, 6, 20, 30, 1'b0);
    chk("R4 right clamped", int'(brd_right), 0);
    chk("R4 bottom normal", int'(brd_bottom), 12);
    chk("R5 err set", int'(brd_err), 1);
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    chk("R5 err sticky", int'(brd_err), 1);
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
    chk("R5 err cleared", int'(brd_err), 0);
    // raw -1 turned into +1 by widening: no clamp, no error
    frame(64, 48, 50, 6, 15, 30, 1'b1);
    chk("R4 widen rescues", int'(brd_right), 1);
    chk("R5 no err after widen", int'(brd_err), 0);
    // bottom negative while clear is requested: set wins
    @(negedge clk);
    h_active = 64; v_active = 20; rect_x = 4; rect_y = 6; rect_w = 40; rect_h = 30;
    dbg_widen = 1'b0; frame_start = 1'b1; err_clear = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; err_clear = 1'b0;
    chk("R4 bottom clamped", int'(brd_bottom), 0);
    chk("R5 set beats clear", int'(brd_err), 1);
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic t_viewport;
    @(negedge clk);
    src_x = 5; src_y = 7; src_w = 33; src_h = 21; fmt_420 = 1'b0;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    chk("R6 luma_x", int'(luma_x), 4);
    chk("R6 luma_y", int'(luma_y), 6);
    chk("R6 luma_w", int'(luma_w), 32);
    chk("R6 luma_h", int'(luma_h), 20);
    chk("R7 chroma copy w", int'(chroma_w), 32);
    chk("R7 chroma copy y", int'(chroma_y), 6);
    @(negedge clk); fmt_420 = 1'b1;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    chk("R7 chroma half x", int'(chroma_x), 2);
    chk("R7 chroma half y", int'(chroma_y), 3);
    chk("R7 chroma half w", int'(chroma_w), 16);
    chk("R7 chroma half h", int'(chroma_h), 10);
    chk("R7 luma kept", int'(luma_w), 32);
    // width rounds to zero: nothing updates
    @(negedge clk); src_x = 11; src_w = 1; src_h = 40; fmt_420 = 1'b0;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    chk("R8 luma_x held", int'(luma_x), 4);
    chk("R8 luma_w held", int'(luma_w), 32);
    chk("R8 chroma_w held", int'(chroma_w), 16);
    chk("R8 chroma_h held", int'(chroma_h), 10);
  endtask

  task automatic t_no_frame;
    @(negedge clk);
    rect_x = 1; rect_w = 2; h_active = 10; dbg_widen = 1'b1;
    src_x = 20; src_w = 50; src_h = 50; edge_mode = 1'b1;
    @(negedge clk);
    chk("R9 left held", int'(brd_left), 4);
    chk("R9 right held", int'(brd_right), 20);
    chk("R9 luma held", int'(luma_w), 32);
    // classification keeps using latched rect x=4 w=40 and constant fill
    pixel(1'b1, 3, 10, 1'b0, 1'b1, 4, 10);
  endtask

  task automatic t_pixels;
    @(negedge clk); edge_mode = 1'b0;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    pixel(1'b1, 4, 6, 1'b1, 1'b0, 4, 6);
    pixel(1'b1, 43, 35, 1'b1, 1'b0, 43, 35);
    pixel(1'b1, 44, 35, 1'b0, 1'b1, 43, 35);
    pixel(1'b1, 10, 40, 1'b0, 1'b1, 10, 35);
    pixel(1'b1, 0, 0, 1'b0, 1'b1, 4, 6);
    pixel(1'b0, 20, 20, 1'b0, 1'b0, 0, 0);
    @(negedge clk); edge_mode = 1'b1;
    frame(64, 48, 4, 6, 40, 30, 1'b0);
    pixel(1'b1, 60, 2, 1'b0, 1'b0, 43, 6);
    pixel(1'b1, 20, 20, 1'b1, 1'b0, 20, 20);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_borders();
    t_clamp();
    t_viewport();
    t_no_frame();
    t_pixels();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule